// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Manager

This block runs the power enables, overcurrent status and indicator outputs for a set of downstream hub ports. The protocol side issues single-cycle strobes: turn power on for one port, turn power off, or clear one port's overcurrent-change flag. A level input says whether the hub has been configured. While that level is low, no port can be powered. Each port has an overcurrent input. It is resynchronised, and an overcurrent cuts that port's power. It also records a status flag and a sticky change flag.

Each port has an indicator output. It is lit while the port is both powered and enabled by the repeater. After an overcurrent it flashes as a square wave. A shared phase generator drives the flashing. It counts pulses of a slow timebase tick and flips after a set number of them, which gives a period of about one second when the tick is 1 kHz and the default count is used. The flashing stops when the host removes power or when the configuration is dropped, which happens on re-enumeration. The strobes have no back-pressure: one may arrive on every cycle, and each is acted on at the clock edge where it is sampled.

Top module: `hub_port_power`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `pwr_en`, `oc_status`, `oc_change` and `led` are all zero.
- R2: A `set_pwr` strobe with `req_port` = i turns on `pwr_en[i]` one cycle later, provided `configured` is high and `oc_status[i]` is low. With `configured` low the strobe is ignored.
- R3: A `clr_pwr` strobe turns off every bit of `pwr_en` one cycle later, whatever `req_port` holds. If a `set_pwr` arrives in the same cycle, the clear wins.
- R4: When `configured` is low, every bit of `pwr_en` is zero one cycle later.
- R5: `oc_status[i]` is `oc_in[i]` delayed by exactly two clock cycles (two synchroniser flops).
- R6: While `oc_status[i]` is high, `pwr_en[i]` is zero on the next cycle, and any `set_pwr` for port i is ignored.
- R7: One cycle after `oc_status[i]` rises, `oc_change[i]` is set. It stays set until a `clr_chg` strobe with `req_port` = i, and it reads zero one cycle after that strobe. A new rise in the same cycle as the strobe wins over the clear.
- R8: When port i is not flashing, `led[i]` equals `port_en[i] & pwr_en[i]`, combinationally.
- R9: When `oc_status[i]` rises, port i starts flashing on the next cycle. While it flashes, `led[i]` follows a shared phase. The phase is 0 after reset and flips on every `HALF_TICKS`-th `tick` pulse.
- R10: Flashing on all ports stops one cycle after a `clr_pwr` strobe, or one cycle after a cycle with `configured` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| configured | input | 1 | High while the hub is configured |
| set_pwr | input | 1 | Strobe: power on the port named by `req_port` |
| clr_pwr | input | 1 | Strobe: power off all ports |
| clr_chg | input | 1 | Strobe: clear the overcurrent-change flag of `req_port` |
| req_port | input | PW | Port index for `set_pwr` and `clr_chg` |
| tick | input | 1 | Slow timebase pulse, one cycle wide |
| oc_in | input | NPORTS | Overcurrent inputs, asynchronous, active high |
| port_en | input | NPORTS | Port-enabled levels from the repeater |
| pwr_en | output | NPORTS | Power switch enables, active high |
| oc_status | output | NPORTS | Synchronised overcurrent status |
| oc_change | output | NPORTS | Sticky overcurrent-change flags |
| led | output | NPORTS | Status indicators |

## Verification
The bench builds the block with `NPORTS` = 4 and `HALF_TICKS` = 3. At that count a full flash period takes only six tick pulses, so many phase flips fall inside a short run and land in every relation to overcurrent rises, clears and deconfiguration. The four ports exercise every value of the two-bit `req_port`, including the highest index. This means a mis-decoded port hit shows up on some port.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  // Request bundle shared by every port cell.
  typedef struct packed {
    logic cfg;
    logic set_pwr;
    logic clr_pwr;
    logic clr_chg;
  } ppm_cmd_t;
endpackage

// File: rtl/ppm_sync.sv
module ppm_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  // Two flops for metastability (R5), a third for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/ppm_blink.sv
module ppm_blink #(
  parameter int HALF_TICKS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic phase
);
  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;

  // Shared flash phase: flips on every HALF_TICKS-th tick (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        phase <= ~phase;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ppm_port.sv
module ppm_port
  import ppm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ppm_cmd_t cmd,
  input  logic     hit,
  input  logic     oc_lvl,
  input  logic     oc_rise,
  input  logic     phase,
  input  logic     link_up,
  output logic     pwr,
  output logic     chg,
  output logic     led
);
  logic flash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr     <= 1'b0;
      chg     <= 1'b0;
      flash_q <= 1'b0;
    end else begin
      // R2 R3 R4 R6: any off-condition beats a set request.
      if (!cmd.cfg || cmd.clr_pwr || oc_lvl) pwr <= 1'b0;
      else if (cmd.set_pwr && hit)          pwr <= 1'b1;
      // R7: a new fault wins over the clear request.
      if (oc_rise)                  chg <= 1'b1;
      else if (cmd.clr_chg && hit)  chg <= 1'b0;
      // R9 R10
      if (!cmd.cfg || cmd.clr_pwr)  flash_q <= 1'b0;
      else if (oc_rise)             flash_q <= 1'b1;
    end
  end

  // R8 R9
  assign led = flash_q ? phase : (link_up & pwr);
endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
  import ppm_pkg::*;
#(
  parameter int NPORTS     = 4,
  parameter int HALF_TICKS = 500,
  parameter int PW         = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              configured,
  input  logic              set_pwr,
  input  logic              clr_pwr,
  input  logic              clr_chg,
  input  logic [PW-1:0]     req_port,
  input  logic              tick,
  input  logic [NPORTS-1:0] oc_in,
  input  logic [NPORTS-1:0] port_en,
  output logic [NPORTS-1:0] pwr_en,
  output logic [NPORTS-1:0] oc_status,
  output logic [NPORTS-1:0] oc_change,
  output logic [NPORTS-1:0] led
);
  ppm_cmd_t          cmd;
  logic [NPORTS-1:0] oc_rise;
  logic              phase;

  assign cmd = '{cfg: configured, set_pwr: set_pwr, clr_pwr: clr_pwr, clr_chg: clr_chg};

  ppm_sync #(.W(NPORTS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (oc_in),
    .lvl  (oc_status),
    .rise (oc_rise)
  );

  ppm_blink #(.HALF_TICKS(HALF_TICKS)) u_blink (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .phase(phase)
  );

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    ppm_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .hit    (req_port == PW'(i)),
      .oc_lvl (oc_status[i]),
      .oc_rise(oc_rise[i]),
      .phase  (phase),
      .link_up(port_en[i]),
      .pwr    (pwr_en[i]),
      .chg    (oc_change[i]),
      .led    (led[i])
    );
  end
endmodule

// File: rtl/hub_port_power_chk.sv
module hub_port_power_chk #(
  parameter int NPORTS = 4,
  parameter int PW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              configured,
  input logic              set_pwr,
  input logic              clr_pwr,
  input logic              clr_chg,
  input logic [PW-1:0]     req_port,
  input logic [NPORTS-1:0] pwr_en,
  input logic [NPORTS-1:0] oc_status,
  input logic [NPORTS-1:0] oc_change
);
  assert_clr_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pwr |=> (pwr_en == '0));

  assert_deconfig_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !configured |=> (pwr_en == '0));

  for (genvar i = 0; i < NPORTS; i++) begin : g_chk
    assert_pwr_rise_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en[i]) |-> $past(set_pwr && configured && (req_port == PW'(i))));

    assert_oc_cuts_pwr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oc_status[i] |=> !pwr_en[i]);

    assert_chg_after_oc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_status[i]) |=> oc_change[i]);

    assert_chg_clear_by_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oc_change[i]) |-> $past(clr_chg && (req_port == PW'(i))));
  end
endmodule

bind hub_port_power hub_port_power_chk #(.NPORTS(NPORTS), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .configured(configured),
  .set_pwr   (set_pwr),
  .clr_pwr   (clr_pwr),
  .clr_chg   (clr_chg),
  .req_port  (req_port),
  .pwr_en    (pwr_en),
  .oc_status (oc_status),
  .oc_change (oc_change)
);

// File: tb/hub_port_power_test.sv
`timescale 1ns/1ps
module hub_port_power_test;
  localparam int N  = 4;
  localparam int H  = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic configured = 1'b0, set_pwr = 1'b0, clr_pwr = 1'b0, clr_chg = 1'b0, tick = 1'b0;
  logic [PW-1:0] req_port = '0;
  logic [N-1:0]  oc_in = '0, port_en = '0;
  logic [N-1:0]  pwr_en, oc_status, oc_change, led;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hub_port_power #(.NPORTS(N), .HALF_TICKS(H)) uut (
    .clk(clk), .rst_n(rst_n), .configured(configured), .set_pwr(set_pwr),
    .clr_pwr(clr_pwr), .clr_chg(clr_chg), .req_port(req_port), .tick(tick),
    .oc_in(oc_in), .port_en(port_en), .pwr_en(pwr_en), .oc_status(oc_status),
    .oc_change(oc_change), .led(led)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced at every rising edge.
  int m_s1[N], m_s2[N], m_s3[N], m_pwr[N], m_chg[N], m_fl[N];
  int m_cnt, m_phase;

  function automatic logic [N-1:0] pack(input int a[N]);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (a[i] != 0);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_pwr[i] = 0; m_chg[i] = 0; m_fl[i] = 0;
      end
      m_cnt = 0; m_phase = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit rise, hit;
        rise = (m_s2[i] != 0) && (m_s3[i] == 0);
        hit  = (int'(req_port) == i);
        if (!configured || clr_pwr || m_s2[i] != 0) m_pwr[i] = 0;
        else if (set_pwr && hit) m_pwr[i] = 1;
        if (rise) m_chg[i] = 1;
        else if (clr_chg && hit) m_chg[i] = 0;
        if (!configured || clr_pwr) m_fl[i] = 0;
        else if (rise) m_fl[i] = 1;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = oc_in[i] ? 1 : 0;
      end
      if (tick) begin
        if (m_cnt == H - 1) begin m_cnt = 0; m_phase = 1 - m_phase; end
        else m_cnt++;
      end
    end
    #2;
    if (rst_n && !done) begin
      logic [N-1:0] exp_led;
      for (int i = 0; i < N; i++)
        exp_led[i] = (m_fl[i] != 0) ? (m_phase != 0) : (port_en[i] && m_pwr[i] != 0);
      chk("R2/R3/R4/R6 pwr_en model", pwr_en, pack(m_pwr));
      chk("R5 oc_status model", oc_status, pack(m_s2));
      chk("R7 oc_change model", oc_change, pack(m_chg));
      chk("R8/R9/R10 led model", led, exp_led);
    end
  end

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk("R1 pwr in reset", pwr_en, '0);
    chk("R1 led in reset", led, '0);
    rst_n = 1'b1;
    cyc();
    chk("R1 pwr after reset", pwr_en, '0);
    chk("R1 status after reset", oc_status, '0);
    chk("R1 change after reset", oc_change, '0);
    chk("R1 led after reset", led, '0);

    // Unconfigured set request is ignored.
    port_en = '1;
    set_pwr = 1'b1; req_port = 2'd1; cyc(); set_pwr = 1'b0;
    chk("R2 set ignored unconfigured", pwr_en, 4'b0000);

    configured = 1'b1; cyc();
    set_pwr = 1'b1; req_port = 2'd1; cyc();
    chk("R2 port1 powered", pwr_en, 4'b0010);
    chk("R8 led follows power", led, 4'b0010);
    req_port = 2'd2; cyc(); set_pwr = 1'b0;
    chk("R2 port2 powered", pwr_en, 4'b0110);
    port_en[1] = 1'b0; #1;
    chk("R8 led needs port enable", led, 4'b0100);
    port_en[1] = 1'b1;

    // Overcurrent on port 2.
    oc_in[2] = 1'b1; cyc();
    chk("R5 one flop not yet", oc_status, 4'b0000);
    cyc();
    chk("R5 status after two flops", oc_status, 4'b0100);
    chk("R6 power still on same cycle", pwr_en, 4'b0110);
    cyc();
    chk("R6 overcurrent cuts power", pwr_en, 4'b0010);
    chk("R7 change set", oc_change, 4'b0100);
    chk("R9 flash starts at phase 0", led, 4'b0010);
    set_pwr = 1'b1; req_port = 2'd2; cyc(); set_pwr = 1'b0;
    chk("R6 set ignored during overcurrent", pwr_en, 4'b0010);

    pulse_tick(); pulse_tick(); cyc();
    chk("R9 no flip before count", led, 4'b0010);
    pulse_tick(); cyc();
    chk("R9 flip after HALF_TICKS", led, 4'b0110);

    oc_in[2] = 1'b0; cyc(4);
    chk("R7 change sticky", oc_change, 4'b0100);
    clr_chg = 1'b1; req_port = 2'd0; cyc(); clr_chg = 1'b0;
    chk("R7 clear of other port no effect", oc_change, 4'b0100);
    clr_chg = 1'b1; req_port = 2'd2; cyc(); clr_chg = 1'b0;
    chk("R7 change cleared", oc_change, 4'b0000);
    chk("R9 still flashing", led, 4'b0110);

    set_pwr = 1'b1; req_port = 2'd3; cyc();
    chk("R2 highest port powered", pwr_en, 4'b1010);
    clr_pwr = 1'b1; req_port = 2'd0; cyc(); clr_pwr = 1'b0; set_pwr = 1'b0;
    chk("R3 clear wins, all off", pwr_en, 4'b0000);
    chk("R10 flash stops on clear", led, 4'b0000);

    set_pwr = 1'b1; req_port = 2'd0; cyc(); set_pwr = 1'b0;
    chk("R2 port0 powered", pwr_en, 4'b0001);
    configured = 1'b0; cyc();
    chk("R4 deconfig drops power", pwr_en, 4'b0000);
    configured = 1'b1;

    // Random traffic, compared against the model on every clock.
    for (int c = 0; c < 6000; c++) begin
      configured = ($urandom_range(0, 39) != 0);
      set_pwr    = ($urandom_range(0, 4) == 0);
      clr_pwr    = ($urandom_range(0, 49) == 0);
      clr_chg    = ($urandom_range(0, 9) == 0);
      req_port   = PW'($urandom_range(0, N - 1));
      tick       = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 19) == 0) oc_in[$urandom_range(0, N - 1)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) port_en[$urandom_range(0, N - 1)] ^= 1'b1;
      cyc();
    end
    done = 1'b1;
    finish_run();
  end
endmodule